// File: doc/BRIEF.md
# Conditional Skip and Switch Test Unit

This block executes the testing group of a combinable operate instruction on a 12-bit accumulator machine. Each cycle with `op_valid` high it looks at the instruction word. If the word belongs to the testing group, the block tests the incoming accumulator and link flag for sign, zero and link conditions, and raises a skip request for the program counter logic. It then produces the updated accumulator. That update is an optional clear followed by an optional OR with the console switch register. It can also raise a halt request.

One inversion bit changes how the selected tests combine. With the bit clear, the block skips if any selected condition is true. With the bit set, it skips only if every selected condition is false, which is the De Morgan dual of the first case. With the bit set and no test selected, the skip is unconditional. The tests always see the accumulator as it arrives, before any clear or switch OR is applied. The link flag is read only and is never changed.

All results are registered and appear in the cycle after the word is presented. A small state machine tracks what the last cycle issued:
- `ST_IDLE` means nothing was issued.
- `ST_ISSUE` means a legal word was executed.
- `ST_REJECT` means a testing-group word with its reserved lowest bit set was refused.

Every state moves on each clock edge, as follows:
- It moves to `ST_ISSUE` on a valid legal testing-group word.
- It moves to `ST_REJECT` on a valid testing-group word with bit 0 set.
- It moves to `ST_IDLE` on anything else.

Top module: `opr_test_unit`

## Requirements
- R1: Only a word whose bits [11:8] are 4'b1111 (octal 74xx–77xx) is acted on, and only while `op_valid` is high. Any other word, or no valid, gives no `skip_req`, `halt_req`, `acc_we` or `decode_err` pulse in the next cycle, and leaves `acc_out` unchanged.
- R2: With bit 3 (sense inversion) clear, `skip_req` is the OR of the selected tests. Bit 6 selects "AC negative" (AC bit 11 set), bit 5 selects "AC zero", and bit 4 selects "link set". For example, 7540 skips when AC ≤ 0.
- R3: With bit 3 set, `skip_req` is the AND of the complements of the selected tests. For example, 7550 skips when AC > 0, and 7530 skips when AC ≥ 0 and L = 0. With no test selected (7410), the skip is unconditional.
- R4: The skip tests use the incoming `acc_in`, not the cleared or switch-ORed value. For example, 7640 with AC = 0 skips and leaves AC = 0.
- R5: Bit 7 clears the accumulator before the switch OR.
- R6: Bit 2 ORs `sw_reg` into the accumulator after the clear. Word 7604 therefore loads `acc_out` with `sw_reg`, and 7404 gives `acc_in | sw_reg`.
- R7: Bit 1 raises `halt_req` for the issuing word.
- R8: A testing-group word with bit 0 set raises `decode_err` and asserts no `skip_req`, `halt_req` or `acc_we`. `acc_out` is unchanged.
- R9: Every output appears exactly one clock after the valid word and lasts one cycle. For a legal word, `acc_we` pulses and `acc_out` carries the result. After reset, all pulses are low and `acc_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Instruction word strobe |
| op_word | input | 12 | Instruction word, bit 11 = most significant |
| acc_in | input | 12 | Accumulator before execution |
| link_in | input | 1 | Link flag |
| sw_reg | input | 12 | Console switch register |
| skip_req | output | 1 | Skip request pulse for the program counter |
| halt_req | output | 1 | Halt request pulse |
| acc_we | output | 1 | Accumulator write pulse |
| acc_out | output | 12 | Updated accumulator |
| decode_err | output | 1 | Reserved-bit rejection pulse |

## Verification
A state register stuck in or wrongly entering `ST_ISSUE` or `ST_REJECT` shows up in the cycle after the offending word. It appears as a spurious or missing `acc_we`, `decode_err` or skip pulse. A skip computed on the modified accumulator, or a wrong clear/OR order, appears as a wrong `skip_req` or `acc_out` in that same cycle. Words such as 7640, 7604 and 7530 make these cases visible. Because `acc_out` holds its value between writes, a stray update is also caught on every later idle cycle.

// File: rtl/opr2_pkg.sv
package opr2_pkg;
    localparam int WORD_W = 12;

    typedef struct packed {
        logic grp_ok;
        logic clr;
        logic t_neg;
        logic t_zero;
        logic t_link;
        logic inv;
        logic osr;
        logic hlt;
        logic bad;
    } opr2_fields_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_REJECT = 2'd2
    } opr2_state_t;
endpackage

// File: rtl/opr2_decode.sv
module opr2_decode
    import opr2_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output opr2_fields_t      fld
);
    always_comb begin
        fld.grp_ok = (word[11:8] == 4'b1111);
        fld.clr    = word[7];
        fld.t_neg  = word[6];
        fld.t_zero = word[5];
        fld.t_link = word[4];
        fld.inv    = word[3];
        fld.osr    = word[2];
        fld.hlt    = word[1];
        fld.bad    = word[0];
    end
endmodule

// File: rtl/opr2_cond.sv
module opr2_cond #(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W-1:0] acc,
    input  logic              link,
    input  logic              sel_neg,
    input  logic              sel_zero,
    input  logic              sel_link,
    input  logic              inv,
    output logic              skip
);
    localparam int NTEST = 3;

    logic [NTEST-1:0] sel;
    logic [NTEST-1:0] cond;
    logic [NTEST-1:0] hit_or;
    logic [NTEST-1:0] ok_and;

    assign sel  = {sel_link, sel_zero, sel_neg};
    assign cond = {link, (acc == '0), acc[DATA_W-1]};

    for (genvar i = 0; i < NTEST; i++) begin : g_test
        assign hit_or[i] = sel[i] & cond[i];
        assign ok_and[i] = ~sel[i] | ~cond[i];
    end

    always_comb begin
        if (inv) skip = &ok_and;
        else     skip = |hit_or;
    end
endmodule

// File: rtl/opr2_acc.sv
module opr2_acc #(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] sw,
    input  logic              clr,
    input  logic              osr,
    output logic [DATA_W-1:0] acc_nxt
);
    logic [DATA_W-1:0] after_clr;

    always_comb begin
        after_clr = clr ? '0 : acc;
        acc_nxt   = osr ? (after_clr | sw) : after_clr;
    end
endmodule

// File: rtl/opr_test_unit.sv
module opr_test_unit
    import opr2_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [11:0]       op_word,
    input  logic [DATA_W-1:0] acc_in,
    input  logic              link_in,
    input  logic [DATA_W-1:0] sw_reg,
    output logic              skip_req,
    output logic              halt_req,
    output logic              acc_we,
    output logic [DATA_W-1:0] acc_out,
    output logic              decode_err
);
    opr2_fields_t      fld;
    logic              skip_c;
    logic [DATA_W-1:0] acc_c;
    opr2_state_t       state, state_nxt;
    logic              skip_q, halt_q;
    logic [DATA_W-1:0] acc_q;

    opr2_decode u_dec (.word(op_word), .fld(fld));

    opr2_cond #(.DATA_W(DATA_W)) u_cond (
        .acc(acc_in), .link(link_in),
        .sel_neg(fld.t_neg), .sel_zero(fld.t_zero), .sel_link(fld.t_link),
        .inv(fld.inv), .skip(skip_c)
    );

    opr2_acc #(.DATA_W(DATA_W)) u_acc (
        .acc(acc_in), .sw(sw_reg), .clr(fld.clr), .osr(fld.osr), .acc_nxt(acc_c)
    );

    always_comb begin
        state_nxt = ST_IDLE;
        if (op_valid && fld.grp_ok) begin
            if (fld.bad) state_nxt = ST_REJECT;
            else         state_nxt = ST_ISSUE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            skip_q <= 1'b0;
            halt_q <= 1'b0;
            acc_q  <= '0;
        end else begin
            state <= state_nxt;
            if (state_nxt == ST_ISSUE) begin
                skip_q <= skip_c;
                halt_q <= fld.hlt;
                acc_q  <= acc_c;
            end
        end
    end

    always_comb begin
        skip_req   = 1'b0;
        halt_req   = 1'b0;
        acc_we     = 1'b0;
        decode_err = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_ISSUE: begin
                skip_req = skip_q;
                halt_req = halt_q;
                acc_we   = 1'b1;
            end
            ST_REJECT: decode_err = 1'b1;
            default: ;
        endcase
    end

    assign acc_out = acc_q;

    a_r1_group_only: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_req || halt_req || acc_we || decode_err) |->
            ($past(op_valid) && $past(op_word[11:8]) == 4'hF));

    a_r3_uncond_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && $past(op_word[3]) && $past(op_word[6:4]) == 3'b000) |-> skip_req);

    a_r4_test_sees_input: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && !$past(op_word[3]) && $past(op_word[5]) && $past(acc_in) == '0) |-> skip_req);

    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && $past(op_word[7]) && !$past(op_word[2])) |-> (acc_out == '0));

    a_r6_or_switch: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && $past(op_word[2])) |-> ((acc_out & $past(sw_reg)) == $past(sw_reg)));

    a_r7_halt_source: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> $past(op_word[1]));

    a_r8_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        decode_err |-> (!skip_req && !halt_req && !acc_we && $stable(acc_out)));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_we |-> (acc_out == $past(acc_out)));
endmodule

// File: tb/opr_test_unit_tb_top.sv
module opr_test_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [11:0] op_word = '0;
    logic [11:0] acc_in = '0;
    logic        link_in = 1'b0;
    logic [11:0] sw_reg = '0;
    logic        skip_req, halt_req, acc_we, decode_err;
    logic [11:0] acc_out;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    int exp_skip = 0, exp_halt = 0, exp_we = 0, exp_err = 0, exp_acc = 0;
    string skip_tag = "R9";

    always #(CLK_PERIOD/2) clk = ~clk;

    opr_test_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_word(op_word),
        .acc_in(acc_in), .link_in(link_in), .sw_reg(sw_reg),
        .skip_req(skip_req), .halt_req(halt_req), .acc_we(acc_we),
        .acc_out(acc_out), .decode_err(decode_err)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (word %o)", req, act, exp, op_word);
        end
    endtask

    task automatic compare_all();
        check(skip_tag, int'(skip_req), exp_skip);
        check("R7", int'(halt_req), exp_halt);
        check("R9", int'(acc_we), exp_we);
        check("R8", int'(decode_err), exp_err);
        check("R6", int'(acc_out), exp_acc);
    endtask

    // Behavioural model: result expected one clock after the drive.
    task automatic model(int v, int w, int a, int l, int s);
        int grp, tneg, tzero, tlink, inv, neg, zero, sk, res;
        grp = v && (((w >> 8) & 15) == 15);
        exp_skip = 0; exp_halt = 0; exp_we = 0; exp_err = 0;
        skip_tag = "R1";
        if (!grp) return;
        if (w & 1) begin
            exp_err = 1;
            skip_tag = "R8";
            return;
        end
        tneg = (w >> 6) & 1; tzero = (w >> 5) & 1; tlink = (w >> 4) & 1;
        inv = (w >> 3) & 1;
        neg = (a >> 11) & 1; zero = (a == 0);
        if (inv) begin
            sk = 1;
            if (tneg && neg) sk = 0;
            if (tzero && zero) sk = 0;
            if (tlink && l) sk = 0;
            skip_tag = "R3";
        end else begin
            sk = (tneg && neg) || (tzero && zero) || (tlink && l);
            skip_tag = (tzero && zero) ? "R4" : "R2";
        end
        res = a;
        if ((w >> 7) & 1) res = 0;
        if ((w >> 2) & 1) res = res | s;
        exp_skip = sk; exp_halt = (w >> 1) & 1; exp_we = 1; exp_acc = res;
    endtask

    task automatic step(int v, int w, int a, int l, int s);
        @(negedge clk);
        compare_all();
        op_valid = v[0]; op_word = w[11:0]; acc_in = a[11:0];
        link_in = l[0]; sw_reg = s[11:0];
        model(v, w, a, l, s);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state (R9)
        compare_all();
        step(1, 'o7540, 'o0000, 0, 0);     // R2: AC=0 skips
        step(1, 'o7540, 'o4000, 0, 0);     // R2: negative skips
        step(1, 'o7540, 'o0001, 1, 0);     // R2: positive, no skip
        step(1, 'o7550, 'o0001, 0, 0);     // R3: AC>0 skips
        step(1, 'o7550, 'o4000, 0, 0);     // R3: negative no skip
        step(1, 'o7530, 'o0002, 0, 0);     // R3: AC>=0 and L=0
        step(1, 'o7530, 'o0002, 1, 0);     // R3: L=1 no skip
        step(1, 'o7410, 'o4000, 1, 0);     // R3: unconditional
        step(1, 'o7640, 'o0000, 0, 0);     // R4: skip then clear
        step(1, 'o7640, 'o0123, 0, 0);     // R4/R5: no skip, cleared
        step(1, 'o7604, 'o1234, 0, 'o0055); // R6: load switches
        step(1, 'o7404, 'o1200, 0, 'o0055); // R6: OR
        step(1, 'o7402, 'o0777, 0, 0);     // R7: halt
        step(1, 'o7401, 'o0777, 1, 'o7777); // R8: reserved bit
        step(1, 'o7000, 'o0000, 1, 0);     // R1: other group ignored
        step(0, 'o7410, 'o0000, 0, 0);     // R1: no valid
        step(1, 'o7460, 'o0005, 1, 0);     // R2: link
        step(0, 0, 0, 0, 0);
        for (int i = 0; i < 3000; i++) begin
            int w;
            w = $urandom_range(0, 4095);
            if ($urandom_range(0, 3) != 0) w = w | 'o7400;
            step(int'($urandom_range(0, 4) != 0), w, int'($urandom_range(0, 4095)),
                 int'($urandom_range(0, 1)), int'($urandom_range(0, 4095)));
        end
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        done = 1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end
endmodule